// File: doc/BRIEF.md
# DSP-mode PCM serial port master

This block drives a two-channel, 16-bit PCM serial link as the clock master. It takes one of two source tick streams, divides it down into a bit clock, and raises a frame sync for one bit clock at the start of every frame. On each frame it sends a left word and then a right word, MSB first. It receives two words the same way. Transmit words come from an external FIFO through a pop strobe. Received words go to an external FIFO through a push strobe.

For each direction, software picks one of two data phases. In one, the MSB coincides with the sync bit. In the other, it follows the sync bit by one bit clock. The bit clock can keep running while both directions are idle, or it can stop, low. Divider settings are picked up only at a frame boundary or while the clock is stopped, so a bit-clock phase or a sync pulse is never cut short.

The source clocks are modelled as single-cycle tick inputs in the `clk` domain. All outputs are registers in that domain. The frame length must be at least 33 bit clocks (`frame_div` of 32 or more), so that both words and the late phase fit.

Top module: `pcm_dsp_master`

## Requirements
- R1: Each bit-clock half period lasts `bclk_div`+1 selected source ticks, so the full period is 2*(`bclk_div`+1) ticks. `bclk` changes only in a cycle that follows a selected tick.
- R2: `src_sel`=0 selects `bus_tick` as the divider source and `src_sel`=1 selects `alt_tick`.
- R3: A frame lasts `frame_div`+1 bit clocks. `fsync` goes high at a falling bit-clock edge, at bit position 0 of the frame, and stays high for exactly one bit clock.
- R4: When `tx_late`/`rx_late` is 1, that direction's MSB sits at bit position 1. When it is 0, the MSB sits at position 0, together with the sync bit. The two directions are set independently.
- R5: The transmitter sends the left word and then the right word back to back, MSB first, over 32 consecutive bit positions. `sdo` changes only at falling bit-clock edges and is 0 in every other bit of the frame.
- R6: `sdi` is sampled at rising bit-clock edges. After the last bit of each word, `rx_push` pulses for one cycle with the word on `rx_data`, but only while `rx_en` is 1. No push occurs until a sync bit has been seen after a start.
- R7: At each word start, `tx_pop` pulses and `tx_data` is taken only when `tx_en` and `tx_valid` are both 1. Otherwise the word is sent as zeros and no pop occurs.
- R8: The bit clock runs only while `sclk_on` is 1 and at least one of `tx_en`, `rx_en` or `idle_run` is 1. When stopped it rests low, and a high phase in progress runs to its full length first.
- R9: New `bclk_div`/`frame_div` values take effect at the next frame boundary or while the clock is stopped. A restart always begins a fresh frame at bit position 0.
- R10: After reset, `bclk`, `fsync`, `sdo`, `tx_pop` and `rx_push` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | Source tick from the bus clock |
| alt_tick | input | 1 | Source tick from the alternate audio clock |
| src_sel | input | 1 | Divider source select: 0 bus, 1 alternate |
| bclk_div | input | 9 | Bit-clock divider N; period 2*(N+1) ticks |
| frame_div | input | 9 | Frame divider M; frame of M+1 bit clocks |
| tx_late | input | 1 | Transmit MSB one bit clock after sync |
| rx_late | input | 1 | Receive MSB one bit clock after sync |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| sclk_on | input | 1 | Bit-clock enable |
| idle_run | input | 1 | Keep bit clock running while both directions are idle |
| tx_data | input | 16 | Head word of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO |
| rx_data | output | 16 | Received word |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |

## Verification
A selected tick changes `bclk` one `clk` cycle later. `fsync`, `sdo` and `tx_pop` change in the same cycle as the falling `bclk` transition. `rx_push` and `rx_data` appear in the same cycle that `bclk` first reads high after the word's last bit. The bench samples every output at the falling edge of `clk`, half a cycle after these registers update. Periods and frame lengths are measured as counts of `clk` cycles between sampled edges, and serial bits are captured at each sampled rising `bclk`. With `sdo` looped back to `sdi`, the received words give the alignment of the data phase to the cycle.

// File: rtl/pcm_dsp_pkg.sv
package pcm_dsp_pkg;
  localparam int unsigned DIV_W     = 9;
  localparam int unsigned SMP_W     = 16;
  localparam int unsigned DEF_FRAME = 127;

  typedef enum logic {
    SRC_BUS = 1'b0,
    SRC_ALT = 1'b1
  } src_sel_e;
endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
  parameter int unsigned DIV_W = pcm_dsp_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             bclk,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             idle
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             bclk_q, bclk_d;
  logic             active, hit;

  // A high phase always completes; the low phase starts only when running.
  always_comb begin
    active  = bclk_q | run;
    hit     = tick & active & (cnt_q == act_q);
    rise_ev = hit & ~bclk_q;
    fall_ev = hit & bclk_q;
    idle    = ~run & ~bclk_q;
    bclk_d  = bclk_q ^ hit;
    act_d   = load ? div_in : act_q;
    cnt_d   = cnt_q;
    if (idle) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;

  AST_BCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_q != $past(bclk_q)) |-> $past(tick)); // R1
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int unsigned DIV_W     = pcm_dsp_pkg::DIV_W,
  parameter int unsigned DEF_FRAME = pcm_dsp_pkg::DEF_FRAME
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_ev,
  input  logic             idle,
  input  logic [DIV_W-1:0] frame_in,
  output logic [DIV_W-1:0] pos,
  output logic [DIV_W-1:0] next_pos,
  output logic             wrap,
  output logic             fsync
);
  logic [DIV_W-1:0] pos_q, pos_d;
  logic [DIV_W-1:0] len_q, len_d;
  logic             fs_q, fs_d;

  always_comb begin
    wrap     = fall_ev & (pos_q >= len_q);
    next_pos = wrap ? '0 : pos_q + 1'b1;
    pos_d    = pos_q;
    len_d    = len_q;
    fs_d     = fs_q;
    if (idle) begin
      // Park on the last position so the first falling edge opens a frame.
      pos_d = frame_in;
      len_d = frame_in;
      fs_d  = 1'b0;
    end else if (fall_ev) begin
      pos_d = next_pos;
      fs_d  = wrap;
      if (wrap) len_d = frame_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= DIV_W'(DEF_FRAME);
      len_q <= DIV_W'(DEF_FRAME);
      fs_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      len_q <= len_d;
      fs_q  <= fs_d;
    end
  end

  assign pos   = pos_q;
  assign fsync = fs_q;

  AST_SYNC_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> (pos_q == '0)); // R3
  AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fall_ev) && $past(fs_q)) |-> !fs_q); // R3
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int unsigned DIV_W = pcm_dsp_pkg::DIV_W,
  parameter int unsigned SMP_W = pcm_dsp_pkg::SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_ev,
  input  logic             idle,
  input  logic [DIV_W-1:0] next_pos,
  input  logic             late,
  input  logic             en,
  input  logic             valid,
  input  logic [SMP_W-1:0] data,
  output logic             sdo,
  output logic             pop
);
  localparam int unsigned SPAN = 2 * SMP_W;

  logic [SMP_W-1:0] sh_q, sh_d;
  logic             pop_q, pop_d;
  logic [DIV_W-1:0] base, mid, stop;
  logic             start_w, in_win, take;

  always_comb begin
    base    = {{(DIV_W-1){1'b0}}, late};
    mid     = base + DIV_W'(SMP_W);
    stop    = base + DIV_W'(SPAN);
    start_w = (next_pos == base) | (next_pos == mid);
    in_win  = (next_pos >= base) & (next_pos < stop);
    take    = en & valid;
    sh_d    = sh_q;
    pop_d   = 1'b0;
    if (idle) begin
      sh_d = '0;
    end else if (fall_ev) begin
      if (start_w) begin
        sh_d  = take ? data : '0;
        pop_d = take;
      end else if (in_win) begin
        sh_d = {sh_q[SMP_W-2:0], 1'b0};
      end else begin
        sh_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pop_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      pop_q <= pop_d;
    end
  end

  assign sdo = sh_q[SMP_W-1];
  assign pop = pop_q;

  AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |-> $past(en && valid)); // R7
  AST_POP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |-> $past(fall_ev)); // R7
  AST_SDO_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_q[SMP_W-1] != $past(sh_q[SMP_W-1])) |-> ($past(fall_ev) || $past(idle))); // R5
endmodule

// File: rtl/pcm_rx_des.sv
module pcm_rx_des #(
  parameter int unsigned DIV_W = pcm_dsp_pkg::DIV_W,
  parameter int unsigned SMP_W = pcm_dsp_pkg::SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ev,
  input  logic             idle,
  input  logic [DIV_W-1:0] pos,
  input  logic             late,
  input  logic             en,
  input  logic             sdi,
  output logic [SMP_W-1:0] word,
  output logic             push
);
  localparam int unsigned SPAN = 2 * SMP_W;

  logic [SMP_W-1:0] sh_q, sh_d;
  logic [SMP_W-1:0] word_q, word_d;
  logic             push_q, push_d;
  logic             armed_q, armed_d;
  logic [DIV_W-1:0] base, last0, last1, stop;
  logic             in_win, at_end;

  always_comb begin
    base    = {{(DIV_W-1){1'b0}}, late};
    last0   = base + DIV_W'(SMP_W - 1);
    last1   = base + DIV_W'(SPAN - 1);
    stop    = base + DIV_W'(SPAN);
    in_win  = (pos >= base) & (pos < stop);
    at_end  = (pos == last0) | (pos == last1);
    sh_d    = sh_q;
    word_d  = word_q;
    push_d  = 1'b0;
    armed_d = armed_q;
    if (idle) begin
      armed_d = 1'b0;
    end else if (rise_ev) begin
      if (pos == '0) armed_d = 1'b1;
      if (in_win) begin
        sh_d = {sh_q[SMP_W-2:0], sdi};
        if (at_end && en && armed_q) begin
          word_d = {sh_q[SMP_W-2:0], sdi};
          push_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      word_q  <= '0;
      push_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      word_q  <= word_d;
      push_q  <= push_d;
      armed_q <= armed_d;
    end
  end

  assign word = word_q;
  assign push = push_q;

  AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(en)); // R6
  AST_PUSH_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(rise_ev)); // R6
endmodule

// File: rtl/pcm_dsp_master.sv
module pcm_dsp_master #(
  parameter int unsigned DIV_W     = pcm_dsp_pkg::DIV_W,
  parameter int unsigned SMP_W     = pcm_dsp_pkg::SMP_W,
  parameter int unsigned DEF_FRAME = pcm_dsp_pkg::DEF_FRAME
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  logic             alt_tick,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] bclk_div,
  input  logic [DIV_W-1:0] frame_div,
  input  logic             tx_late,
  input  logic             rx_late,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             sclk_on,
  input  logic             idle_run,
  input  logic [SMP_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_pop,
  output logic [SMP_W-1:0] rx_data,
  output logic             rx_push,
  input  logic             sdi,
  output logic             sdo,
  output logic             bclk,
  output logic             fsync
);
  import pcm_dsp_pkg::*;

  logic             tick, run, idle, rise_ev, fall_ev, wrap;
  logic [DIV_W-1:0] pos, next_pos;

  always_comb begin
    tick = (src_sel == SRC_ALT) ? alt_tick : bus_tick;
    run  = sclk_on & (tx_en | rx_en | idle_run);
  end

  pcm_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .load    (wrap | idle),
    .div_in  (bclk_div),
    .bclk    (bclk),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .idle    (idle)
  );

  pcm_frame_ctr #(.DIV_W(DIV_W), .DEF_FRAME(DEF_FRAME)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_ev  (fall_ev),
    .idle     (idle),
    .frame_in (frame_div),
    .pos      (pos),
    .next_pos (next_pos),
    .wrap     (wrap),
    .fsync    (fsync)
  );

  pcm_tx_ser #(.DIV_W(DIV_W), .SMP_W(SMP_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_ev  (fall_ev),
    .idle     (idle),
    .next_pos (next_pos),
    .late     (tx_late),
    .en       (tx_en),
    .valid    (tx_valid),
    .data     (tx_data),
    .sdo      (sdo),
    .pop      (tx_pop)
  );

  pcm_rx_des #(.DIV_W(DIV_W), .SMP_W(SMP_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_ev (rise_ev),
    .idle    (idle),
    .pos     (pos),
    .late    (rx_late),
    .en      (rx_en),
    .sdi     (sdi),
    .word    (rx_data),
    .push    (rx_push)
  );

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!run) && !$past(bclk)) |-> !bclk); // R8
  AST_FSYNC_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync != $past(fsync)) |-> (($past(bclk) && !bclk) || !$past(run))); // R3
endmodule

// File: tb/pcm_dsp_master_tb_top.sv
module pcm_dsp_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ALT_EVERY  = 3;

  typedef struct packed {
    logic        sel;
    logic [8:0]  n;
    logic [8:0]  m;
    logic        tl;
    logic        rl;
    logic [15:0] l;
    logic [15:0] r;
    logic [15:0] e0;
    logic [15:0] e1;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 9'd0, 9'd32,  1'b0, 1'b0, 16'hA5C3, 16'h3C96, 16'hA5C3, 16'h3C96},
    '{1'b0, 9'd2, 9'd63,  1'b1, 1'b1, 16'h8001, 16'h7FFE, 16'h8001, 16'h7FFE},
    '{1'b1, 9'd1, 9'd40,  1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000},
    '{1'b0, 9'd0, 9'd32,  1'b1, 1'b0, 16'hA5C3, 16'h3C96, 16'h52E1, 16'h9E4B},
    '{1'b0, 9'd1, 9'd127, 1'b0, 1'b1, 16'h1234, 16'hF00F, 16'h2469, 16'hE01E}
  };

  logic        clk, rst_n;
  logic        bus_tick, alt_tick, src_sel;
  logic [8:0]  bclk_div, frame_div;
  logic        tx_late, rx_late, tx_en, rx_en, sclk_on, idle_run;
  logic [15:0] tx_data, rx_data;
  logic        tx_valid, tx_pop, rx_push, sdi, sdo, bclk, fsync;

  logic        fifo_on, idx_clr, mon_clr;
  logic [15:0] word_l, word_r;
  int          idx, pop_cnt;

  int checks = 0;
  int errors = 0;

  pcm_dsp_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .alt_tick(alt_tick),
    .src_sel(src_sel), .bclk_div(bclk_div), .frame_div(frame_div),
    .tx_late(tx_late), .rx_late(rx_late), .tx_en(tx_en), .rx_en(rx_en),
    .sclk_on(sclk_on), .idle_run(idle_run), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_data(rx_data),
    .rx_push(rx_push), .sdi(sdi), .sdo(sdo), .bclk(bclk), .fsync(fsync)
  );

  assign sdi      = sdo;
  assign tx_valid = fifo_on;
  assign tx_data  = idx[0] ? word_r : word_l;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    int k = 0;
    alt_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      alt_tick = (k == ALT_EVERY - 1);
      k = (k + 1) % ALT_EVERY;
    end
  end

  always @(posedge clk) begin
    if (idx_clr) begin
      idx     <= 0;
      pop_cnt <= 0;
    end else if (tx_pop) begin
      idx     <= idx + 1;
      pop_cnt <= pop_cnt + 1;
    end
  end

  int   cyc = 0, last_rise = 0, rise_gap = 0, rises = 0;
  int   gap_min = 0, gap_max = 0;
  int   fs_last = 0, fs_gap = 0, fs_rises = 0, fs_cnt = 0, fs_width = 0;
  int   pos = 0, push_cnt = 0;
  logic prev_bclk = 1'b0, prev_fs = 1'b0;
  logic framebits [0:511];
  logic [15:0] push_w [0:7];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      rises = 0; fs_rises = 0; push_cnt = 0; gap_min = 99999; gap_max = 0;
    end
    if (rx_push) begin
      if (push_cnt < 8) push_w[push_cnt] = rx_data;
      push_cnt = push_cnt + 1;
    end
    if (bclk && !prev_bclk) begin
      if (rises > 0) begin
        rise_gap = cyc - last_rise;
        if (rise_gap < gap_min) gap_min = rise_gap;
        if (rise_gap > gap_max) gap_max = rise_gap;
      end
      last_rise = cyc;
      rises = rises + 1;
      pos = fsync ? 0 : pos + 1;
      if (pos < 512) framebits[pos] = sdo;
    end
    if (fsync && !prev_fs) begin
      if (fs_rises > 0) fs_gap = cyc - fs_last;
      fs_last = cyc;
      fs_rises = fs_rises + 1;
    end
    if (fsync) fs_cnt = fs_cnt + 1;
    if (!fsync && prev_fs) begin
      fs_width = fs_cnt;
      fs_cnt = 0;
    end
    prev_bclk = bclk;
    prev_fs = fsync;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    step(1);
    mon_clr = 1'b1; idx_clr = 1'b1;
    step(1);
    mon_clr = 1'b0; idx_clr = 1'b0;
  endtask

  task automatic stop_port();
    step(1);
    sclk_on = 1'b0; tx_en = 1'b0; rx_en = 1'b0; idle_run = 1'b0;
    step(30);
  endtask

  task automatic cfg(input logic sel, input int n, input int m,
                     input logic tl, input logic rl);
    stop_port();
    src_sel = sel; bclk_div = 9'(n); frame_div = 9'(m);
    tx_late = tl; rx_late = rl;
    step(3);
    clear_mon();
  endtask

  task automatic start(input logic te, input logic re);
    tx_en = te; rx_en = re; sclk_on = 1'b1;
  endtask

  task automatic wait_fs(input int n);
    for (int t = 0; t < 8000 && fs_rises < n; t++) @(posedge clk);
    #1;
  endtask

  task automatic wait_rises(input int n);
    for (int t = 0; t < 8000 && rises < n; t++) @(posedge clk);
    #1;
  endtask

  task automatic count_ones(input int lo, input int hi, output int ones);
    ones = 0;
    for (int i = lo; i <= hi; i++) if (framebits[i] === 1'b1) ones++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the end of the test");
    summary();
    $finish;
  end

  initial begin
    int per, ones;
    rst_n = 1'b0; bus_tick = 1'b1; src_sel = 1'b0;
    bclk_div = '0; frame_div = 9'd32; tx_late = 1'b0; rx_late = 1'b0;
    tx_en = 1'b0; rx_en = 1'b0; sclk_on = 1'b0; idle_run = 1'b0;
    fifo_on = 1'b1; idx_clr = 1'b1; mon_clr = 1'b0;
    word_l = '0; word_r = '0;
    step(4);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    check("R10 bclk", int'(bclk), 0);
    check("R10 fsync", int'(fsync), 0);
    check("R10 sdo", int'(sdo), 0);
    check("R10 pops/pushes", int'(tx_pop) + int'(rx_push), 0);

    // Table: divider, source select, phase and loopback data
    for (int v = 0; v < NVEC; v++) begin
      word_l = VECS[v].l; word_r = VECS[v].r; fifo_on = 1'b1;
      cfg(VECS[v].sel, int'(VECS[v].n), int'(VECS[v].m), VECS[v].tl, VECS[v].rl);
      per = 2 * (int'(VECS[v].n) + 1) * (VECS[v].sel ? ALT_EVERY : 1);
      start(1'b1, 1'b1);
      wait_fs(2);
      check("R1 R2 bit clock period", rise_gap, per);
      check("R3 frame length", fs_gap, per * (int'(VECS[v].m) + 1));
      check("R3 sync width", fs_width, per);
      check("R4 R6 first word", int'(push_w[0]), int'(VECS[v].e0));
      check("R4 R5 second word", int'(push_w[1]), int'(VECS[v].e1));
    end

    // R8 gated idle: enabled clock, no direction, gated mode
    word_l = 16'hFFFF; word_r = 16'hFFFF;
    cfg(1'b0, 0, 32, 1'b0, 1'b0);
    sclk_on = 1'b1;
    step(100);
    check("R8 gated idle clock stopped", rises, 0);
    idle_run = 1'b1;
    step(100);
    check("R8 continuous idle clock runs", int'(rises > 10), 1);
    sclk_on = 1'b0;
    step(20);
    clear_mon();
    step(100);
    check("R8 clock enable off", rises + int'(bclk), 0);
    idle_run = 1'b0;

    // R4 R5 bit placement within a frame, coinciding MSB
    cfg(1'b0, 0, 40, 1'b0, 1'b0);
    start(1'b1, 1'b0);
    wait_fs(3);
    check("R4 MSB at sync bit", int'(framebits[0]), 1);
    count_ones(0, 31, ones);
    check("R5 data bits", ones, 32);
    count_ones(32, 40, ones);
    check("R5 tail bits zero", ones, 0);

    // R4 R5 late MSB
    cfg(1'b0, 0, 40, 1'b1, 1'b0);
    start(1'b1, 1'b0);
    wait_fs(3);
    check("R4 sync bit empty when late", int'(framebits[0]), 0);
    check("R4 MSB one bit after sync", int'(framebits[1]), 1);
    count_ones(33, 40, ones);
    check("R5 tail bits zero late", ones, 0);

    // R7 empty transmit FIFO sends zeros
    fifo_on = 1'b0;
    cfg(1'b0, 0, 32, 1'b0, 1'b0);
    start(1'b1, 1'b1);
    wait_fs(2);
    check("R7 no pop when empty", pop_cnt, 0);
    check("R7 zero word 0", int'(push_w[0]), 0);
    check("R7 zero word 1", int'(push_w[1]), 0);
    fifo_on = 1'b1;

    // R6 no push while receive is disabled
    cfg(1'b0, 0, 32, 1'b0, 1'b0);
    start(1'b1, 1'b0);
    wait_fs(3);
    check("R6 no push without rx_en", push_cnt, 0);
    check("R7 pops with tx_en", int'(pop_cnt >= 4), 1);

    // R9 divider change inside a frame waits for the boundary
    cfg(1'b0, 1, 32, 1'b0, 1'b0);
    start(1'b1, 1'b1);
    wait_fs(1);
    step(40);
    bclk_div = 9'd3;
    clear_mon();
    wait_fs(1);
    check("R9 old period min", gap_min, 4);
    check("R9 old period max", gap_max, 4);
    clear_mon();
    wait_rises(6);
    check("R9 new period min", gap_min, 8);
    check("R9 new period max", gap_max, 8);

    stop_port();
    summary();
    $finish;
  end
endmodule